// File: doc/BRIEF.md
# Per-Phase Peak Current Limiter

This block guards one phase of a multiphase converter against excessive current in either direction. In every clock cycle it compares a signed phase current sample against a positive peak limit and a negative peak limit. While the sample is outside that window, it inverts the PWM drive of the phase so that the current is pushed back toward the window. The inversion lasts only as long as the excursion lasts, so the limiting acts pulse by pulse.

Each polarity has its own run counter, which advances once per switching period on a period tick. The counter advances when that period saw at least one excursion of its polarity. Otherwise it returns to zero. When a run reaches a programmed length, a latched fault flag for that polarity is raised. A length of zero selects indefinite limiting, in which the current is limited but no fault is ever raised. The fault flags stay high until a clear input drops them.

Top module: `phase_peak_limiter`

## Requirements
- R1: A positive excursion is present in a cycle when `cur_i > pos_lim_i`, and a negative excursion when `cur_i < neg_lim_i`. Both comparisons are strict and use signed two's complement values. A sample equal to a limit is not an excursion.
- R2: In any cycle with an excursion of either polarity, `pwm_o` equals the inverse of `pwm_i` in that same cycle, with no register in the path.
- R3: In any cycle with `neg_lim_i <= cur_i <= pos_lim_i`, `pwm_o` equals `pwm_i`. Inversion therefore releases in the same cycle in which the current returns inside the window.
- R4: A switching period runs from the cycle after one `period_tick_i` pulse up to and including the cycle of the next pulse. At each tick, the counter of a polarity increments if that period held an excursion of that polarity and is set to zero otherwise. The counter saturates at 2^CNT_W-1 and does not wrap.
- R5: With a nonzero length N on `pos_len_i` or `neg_len_i`, the matching fault flag rises in the cycle after the tick that ends the Nth consecutive limited period of that polarity, or any later tick while the run continues.
- R6: A length of 0 selects indefinite limiting. The matching fault flag never rises, and PWM inversion per R2 continues.
- R7: A fault flag holds until `fault_clr_i` is high. A clear in a cycle that has no set condition drops the flag on the next cycle. When set and clear fall in the same cycle, the set wins.
- R8: After reset both fault flags are 0 and both run counters are 0.
- R9: The two polarities are independent. Excursions, counts and faults of one polarity never change the other polarity's fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM drive from the modulator |
| cur_i | input | CUR_W | Signed phase current sample |
| pos_lim_i | input | CUR_W | Signed positive peak limit |
| neg_lim_i | input | CUR_W | Signed negative peak limit |
| period_tick_i | input | 1 | One-cycle pulse marking the end of a switching period |
| pos_len_i | input | CNT_W | Run length for the positive fault; 0 means indefinite |
| neg_len_i | input | CNT_W | Run length for the negative fault; 0 means indefinite |
| fault_clr_i | input | 1 | Clears both latched fault flags |
| pwm_o | output | 1 | PWM drive to the power stage, inverted during excursions |
| pos_fault_o | output | 1 | Latched positive run fault |
| neg_fault_o | output | 1 | Latched negative run fault |

## Verification
Two events can fall in the same cycle: a fault clear and a tick that completes a qualifying run. The bench provokes this by holding `fault_clr_i` high exactly in the tick cycle of a period that reaches the run length, and expects the flag to be high afterwards. It also places the clear early in a period whose tick carries no set condition, and expects the flag to be low. The saturation case is judged the same way. The bench clears a fault while a run sits at its ceiling, and a wrapping counter would then fail to raise the fault again on the next limited tick.

// File: rtl/plim_pkg.sv
package plim_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } lim_ev_t;
endpackage

// File: rtl/plim_cmp.sv
module plim_cmp
  import plim_pkg::*;
#(
  parameter int unsigned CUR_W = 12
) (
  input  logic signed [CUR_W-1:0] cur_i,
  input  logic signed [CUR_W-1:0] pos_lim_i,
  input  logic signed [CUR_W-1:0] neg_lim_i,
  output lim_ev_t                 ev_o
);
  always_comb begin
    ev_o.pos = cur_i > pos_lim_i;
    ev_o.neg = cur_i < neg_lim_i;
  end
endmodule

// File: rtl/plim_run.sv
module plim_run #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             clr_i,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ev;
  logic [CNT_W-1:0] cnt_nx;
  logic             set_fault;

  assign ev        = seen_q | hit_i;
  assign cnt_nx    = (cnt_q == CntMax) ? cnt_q : cnt_q + CNT_W'(1);
  assign set_fault = tick_i && ev && (len_i != '0) && (cnt_nx >= len_i);

  // sticky excursion flag for the open period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (tick_i) seen_q <= 1'b0;
    else if (hit_i)  seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= ev ? cnt_nx : '0;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fault_o <= 1'b0;
    else if (set_fault) fault_o <= 1'b1;
    else if (clr_i)     fault_o <= 1'b0;
  end
endmodule

// File: rtl/phase_peak_limiter.sv
module phase_peak_limiter
  import plim_pkg::*;
#(
  parameter int unsigned CUR_W = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pwm_i,
  input  logic signed [CUR_W-1:0] cur_i,
  input  logic signed [CUR_W-1:0] pos_lim_i,
  input  logic signed [CUR_W-1:0] neg_lim_i,
  input  logic                    period_tick_i,
  input  logic [CNT_W-1:0]        pos_len_i,
  input  logic [CNT_W-1:0]        neg_len_i,
  input  logic                    fault_clr_i,
  output logic                    pwm_o,
  output logic                    pos_fault_o,
  output logic                    neg_fault_o
);
  localparam int unsigned NPol = 2;

  lim_ev_t          ev;
  logic [NPol-1:0]  hit;
  logic [CNT_W-1:0] len [NPol];
  logic [NPol-1:0]  fault;

  plim_cmp #(.CUR_W(CUR_W)) cmp_i (
    .cur_i    (cur_i),
    .pos_lim_i(pos_lim_i),
    .neg_lim_i(neg_lim_i),
    .ev_o     (ev)
  );

  assign hit    = {ev.neg, ev.pos};
  assign len[0] = pos_len_i;
  assign len[1] = neg_len_i;

  for (genvar p = 0; p < NPol; p++) begin : g_pol
    plim_run #(.CNT_W(CNT_W)) run_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (period_tick_i),
      .hit_i  (hit[p]),
      .len_i  (len[p]),
      .clr_i  (fault_clr_i),
      .fault_o(fault[p])
    );
  end

  assign pwm_o       = pwm_i ^ (|hit);
  assign pos_fault_o = fault[0];
  assign neg_fault_o = fault[1];
endmodule

// File: rtl/plim_chk.sv
module plim_chk #(
  parameter int unsigned CUR_W = 12,
  parameter int unsigned CNT_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    pwm_i,
  input logic signed [CUR_W-1:0] cur_i,
  input logic signed [CUR_W-1:0] pos_lim_i,
  input logic signed [CUR_W-1:0] neg_lim_i,
  input logic                    period_tick_i,
  input logic [CNT_W-1:0]        pos_len_i,
  input logic [CNT_W-1:0]        neg_len_i,
  input logic                    fault_clr_i,
  input logic                    pwm_o,
  input logic                    pos_fault_o,
  input logic                    neg_fault_o
);
  p_invert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i > pos_lim_i || cur_i < neg_lim_i) |-> (pwm_o != pwm_i));

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i <= pos_lim_i && cur_i >= neg_lim_i) |-> (pwm_o == pwm_i));

  p_pos_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_fault_o) |-> $past(period_tick_i));

  p_neg_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(neg_fault_o) |-> $past(period_tick_i));

  p_pos_indef_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_fault_o) |-> ($past(pos_len_i) != '0));

  p_neg_indef_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(neg_fault_o) |-> ($past(neg_len_i) != '0));

  p_pos_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_fault_o && !fault_clr_i) |=> pos_fault_o);

  p_pos_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_clr_i && !period_tick_i) |=> !pos_fault_o && !neg_fault_o);

  p_neg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_fault_o && !fault_clr_i) |=> neg_fault_o);
endmodule

bind phase_peak_limiter plim_chk #(.CUR_W(CUR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/phase_peak_limiter_tb.sv
`timescale 1ns/1ps
module phase_peak_limiter_tb_top;
  localparam int CUR_W = 12;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0;
  logic signed [CUR_W-1:0] cur = '0;
  logic signed [CUR_W-1:0] pos_lim = 12'sd100;
  logic signed [CUR_W-1:0] neg_lim = -12'sd100;
  logic tick = 1'b0;
  logic [CNT_W-1:0] pos_len = '0;
  logic [CNT_W-1:0] neg_len = '0;
  logic clr = 1'b0;
  logic pwm_out, pos_flt, neg_flt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phase_peak_limiter #(.CUR_W(CUR_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .cur_i(cur),
    .pos_lim_i(pos_lim), .neg_lim_i(neg_lim), .period_tick_i(tick),
    .pos_len_i(pos_len), .neg_len_i(neg_len), .fault_clr_i(clr),
    .pwm_o(pwm_out), .pos_fault_o(pos_flt), .neg_fault_o(neg_flt)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one 4-cycle period; clr_mode 0 none, 1 early cycle, 2 tick cycle
  task automatic period(input bit pev, input bit nev, input int clr_mode);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cur  = (c == 1 && pev) ? pos_lim + 12'sd5 :
             (c == 2 && nev) ? neg_lim - 12'sd5 : 12'sd0;
      tick = (c == 3);
      clr  = (c == 0 && clr_mode == 1) || (c == 3 && clr_mode == 2);
    end
    @(negedge clk);
    tick = 1'b0; clr = 1'b0; cur = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pos_flt, 1'b0, "R8 pos fault in reset");
    chk(neg_flt, 1'b0, "R8 neg fault in reset");
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R3: window sweep over several limit pairs
    for (int lp = -2; lp <= 4; lp += 3) begin
      for (int ln = -6; ln <= -1; ln += 5) begin
        for (int v = -9; v <= 9; v++) begin
          for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            pos_lim = 12'(lp); neg_lim = 12'(ln); cur = 12'(v); pwm = p[0];
            #1;
            chk(pwm_out, p[0] ^ ((v > lp) || (v < ln)),
                (v > lp || v < ln) ? "R2 R1 inversion" : "R3 R1 pass");
          end
        end
      end
    end
    @(negedge clk);
    pos_lim = 12'sd100; neg_lim = -12'sd100; cur = '0; pwm = 1'b0;
    period(0, 0, 1);
    chk(pos_flt, 1'b0, "R8 R4 clean start");

    // R4 R5 R6 R9: thresholds 0..5, runs up to 7 periods, each polarity
    for (int pol = 0; pol < 2; pol++) begin
      for (int thr = 0; thr <= 5; thr++) begin
        pos_len = (pol == 0) ? CNT_W'(thr) : CNT_W'(1);
        neg_len = (pol == 1) ? CNT_W'(thr) : CNT_W'(1);
        period(0, 0, 1);
        chk(pol == 0 ? pos_flt : neg_flt, 1'b0, "R7 clear before run");
        for (int k = 1; k <= 7; k++) begin
          period(pol == 0, pol == 1, 0);
          chk(pol == 0 ? pos_flt : neg_flt, (thr != 0) && (k >= thr),
              thr == 0 ? "R6 indefinite" : "R5 run length");
          chk(pol == 0 ? neg_flt : pos_flt, 1'b0, "R9 other polarity");
        end
      end
    end

    // R4: broken run restarts count
    pos_len = 3; neg_len = 0;
    period(0, 0, 1);
    period(1, 0, 0); period(1, 0, 0); period(0, 0, 0);
    period(1, 0, 0); period(1, 0, 0);
    chk(pos_flt, 1'b0, "R4 reset on clean period");
    period(1, 0, 0);
    chk(pos_flt, 1'b1, "R4 R5 run after restart");

    // R4: event on tick cycle itself counts
    pos_len = 1;
    period(0, 0, 1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      tick = (c == 3);
      cur  = (c == 3) ? 12'sd200 : 12'sd0;
    end
    @(negedge clk); tick = 0; cur = 0; #1;
    chk(pos_flt, 1'b1, "R4 tick-cycle event counts");

    // R7: hold, clear, and set-over-clear collision
    pos_len = 2;
    period(0, 0, 1);
    period(1, 0, 0); period(1, 0, 0);
    chk(pos_flt, 1'b1, "R5 fault at 2");
    period(0, 0, 0);
    chk(pos_flt, 1'b1, "R7 hold without clear");
    period(1, 0, 1);
    chk(pos_flt, 1'b0, "R7 early clear drops");
    period(1, 0, 2);
    chk(pos_flt, 1'b1, "R7 set wins over clear");

    // R4 saturation: run at ceiling, clear, next limited tick sets again
    pos_len = 4'd15;
    period(0, 0, 1);
    for (int k = 0; k < 17; k++) period(1, 0, 0);
    chk(pos_flt, 1'b1, "R5 fault at 15");
    period(1, 0, 1);
    chk(pos_flt, 1'b1, "R4 saturated count re-sets fault");

    // R9: negative run alone with positive armed
    pos_len = 1; neg_len = 2;
    period(0, 0, 1);
    period(0, 1, 0); period(0, 1, 0);
    chk(neg_flt, 1'b1, "R9 neg fault");
    chk(pos_flt, 1'b0, "R9 pos untouched");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule